// File: doc/BRIEF.md
# Three-Level DMA Address Translator

This block turns a DMA address issued by a device function into a host memory address. It reads up to three 64-bit table entries from memory: region, then segment, then page. It also produces a permission result for the access. Each request is checked against the function's own setup before any memory read. A single reserved interrupt-message address skips translation entirely. A request with no translation table configured fails with its own cause code. So does a request that falls outside the function's window.

The block takes one request at a time. It samples the configuration (table origin, window base, window limit) when it accepts the request. Every accepted request produces exactly one result pulse. A failed request also raises an error pulse in the same cycle, carrying a cause code, a qualifier bit and the faulting address. Any error also sets two sticky per-function flags, an error flag and a store-blocked flag, which only reset clears. The memory side is a valid/ready read port with at most one read in flight.

Top module: `dma_xlat_walker`

## Requirements
- R1: A request whose address equals the parameter MSI_ADDR returns that same address with permission RW (2'b11). It makes no memory read and raises no error, whatever the origin, base and limit hold. The result stands for a 4 KiB granule.
- R2: If the request is not the message address and cfg_origin is zero, the result has permission NONE (2'b00) and address 0. An error pulse carries cause 1 and qualifier 0, and no memory read is made.
- R3: Otherwise, an address below cfg_base or above cfg_limit gives permission NONE and address 0. An error pulse carries cause 2 and qualifier 0, and no memory read is made.
- R4: The walk reads entries in the order region, segment, page. The region index is address bits [41:31], the segment index is bits [30:20] and the page index is bits [19:12]. Each entry address is the table base plus eight times the index. The first table base is cfg_origin with bits [11:0] cleared, and each later base is the previous entry with bits [11:0] cleared.
- R5: A region entry is used only if bits [3:2] are 2'b11 and its address field is nonzero. A segment entry is used only if bits [3:2] are 2'b10 and its address field is nonzero. Otherwise the walk stops with no further read and ends as in R6.
- R6: A zero page entry, or a walk stopped under R5, gives permission NONE and address 0. An error pulse carries cause 3 and qualifier 1.
- R7: A nonzero page entry gives the address {entry[63:12], request[11:0]}. The permission is NONE if entry bit 10 is set and RW if it is clear, with no error pulse.
- R8: At most one memory read is outstanding. While mem_req_valid waits for mem_req_ready, it stays high with a stable address.
- R9: Every accepted request gives exactly one resp_valid pulse, and req_ready stays low from acceptance until that pulse. Any error pulse is followed by fn_error and fn_blocked set, and these stay set until reset.
- R10: After reset, req_ready is 1 and resp_valid, err_valid, mem_req_valid, fn_error and fn_blocked are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle, request accepted on this cycle |
| req_addr | input | AW | Device DMA address |
| cfg_origin | input | AW | Region table origin; bits [11:0] are flags; zero means unconfigured |
| cfg_base | input | AW | Lowest legal DMA address |
| cfg_limit | input | AW | Highest legal DMA address |
| resp_valid | output | 1 | One-cycle result pulse |
| resp_addr | output | AW | Translated address |
| resp_perm | output | 2 | 2'b11 read/write, 2'b00 none |
| err_valid | output | 1 | One-cycle error pulse, coincident with resp_valid |
| err_cause | output | 2 | 1 no table, 2 out of window, 3 walk fault |
| err_qual | output | 1 | Qualifier bit, set on walk faults |
| err_addr | output | AW | Request address of the failed translation |
| fn_error | output | 1 | Sticky error flag |
| fn_blocked | output | 1 | Sticky store-blocked flag |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | AW | Byte address of the 64-bit entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry contents |

## Verification
Some properties are checked on every cycle. These are the memory handshake rules, that is the single outstanding read and the stable request while it waits. The others are the coupling of each error pulse to a NONE result, the stickiness of the function flags, and req_ready staying low during a walk. Only the scoreboard scenarios show the rest. That covers which table entries are fetched and in what order, the tag tests at each level, the cause and qualifier for each failure, the priority of the message bypass over the origin and window checks, and the composed address and permission. The bench compares each against a separate model of the tables.

// File: rtl/dma_xlat_pkg.sv
package dma_xlat_pkg;
   localparam logic [1:0] PERM_NONE = 2'b00;
   localparam logic [1:0] PERM_RW   = 2'b11;

   localparam logic [1:0] CAUSE_NONE     = 2'd0;
   localparam logic [1:0] CAUSE_NO_SPACE = 2'd1;
   localparam logic [1:0] CAUSE_RANGE    = 2'd2;
   localparam logic [1:0] CAUSE_WALK     = 2'd3;

   localparam logic [1:0] TAG_REGION  = 2'b11;
   localparam logic [1:0] TAG_SEGMENT = 2'b10;
   localparam int TAG_LSB   = 2;
   localparam int INVAL_BIT = 10;

   typedef enum logic [1:0] {LVL_REGION = 2'd0, LVL_SEGMENT = 2'd1, LVL_PAGE = 2'd2} level_e;
   typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_ISSUE = 2'd1, ST_WAIT = 2'd2} walk_st_e;
endpackage

// File: rtl/dma_xlat_precheck.sv
module dma_xlat_precheck
   import dma_xlat_pkg::*;
#(
   parameter int          AW       = 64,
   parameter logic [AW-1:0] MSI_ADDR = '0,
   parameter bit          MSI_EN   = 1'b1
) (
   input  logic [AW-1:0] addr,
   input  logic [AW-1:0] origin,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] limit,
   output logic          is_msi,
   output logic          fail,
   output logic [1:0]    cause
);
   generate
      if (MSI_EN) begin : g_msi
         assign is_msi = (addr == MSI_ADDR);
      end else begin : g_no_msi
         assign is_msi = 1'b0;
      end
   endgenerate

   always_comb begin
      fail  = 1'b0;
      cause = CAUSE_NONE;
      if (!is_msi) begin
         if (origin == '0) begin
            fail  = 1'b1;
            cause = CAUSE_NO_SPACE;
         end else if ((addr < base) || (addr > limit)) begin
            fail  = 1'b1;
            cause = CAUSE_RANGE;
         end
      end
   end
endmodule

// File: rtl/dma_xlat_index.sv
module dma_xlat_index
   import dma_xlat_pkg::*;
#(
   parameter int AW         = 64,
   parameter int PAGE_SHIFT = 12,
   parameter int PX_W       = 8,
   parameter int SX_W       = 11,
   parameter int RX_W       = 11
) (
   input  logic [AW-1:0] addr,
   input  logic [AW-1:0] table_base,
   input  level_e        level,
   output logic [AW-1:0] entry_addr
);
   localparam int SX_SHIFT = PAGE_SHIFT + PX_W;
   localparam int RX_SHIFT = SX_SHIFT + SX_W;

   generate
      if (RX_SHIFT + RX_W > AW) begin : g_bad_fields
         $error("index fields exceed the address width");
      end
      if (RX_W > AW - 3 || SX_W > AW - 3) begin : g_bad_idx
         $error("index too wide for entry scaling");
      end
   endgenerate

   logic [AW-1:0] idx;

   always_comb begin
      idx = '0;
      case (level)
         LVL_REGION:  idx[RX_W-1:0] = addr[RX_SHIFT +: RX_W];
         LVL_SEGMENT: idx[SX_W-1:0] = addr[SX_SHIFT +: SX_W];
         default:     idx[PX_W-1:0] = addr[PAGE_SHIFT +: PX_W];
      endcase
   end

   assign entry_addr = table_base + {idx[AW-4:0], 3'b000};
endmodule

// File: rtl/dma_xlat_entry_dec.sv
module dma_xlat_entry_dec
   import dma_xlat_pkg::*;
#(
   parameter int AW         = 64,
   parameter int PAGE_SHIFT = 12
) (
   input  logic [63:0]   entry,
   input  level_e        level,
   output logic [AW-1:0] next_base,
   output logic          usable,
   output logic          page_inval
);
   localparam logic [AW-1:0] LOW_MASK = (AW'(1) << PAGE_SHIFT) - AW'(1);

   generate
      if (AW > 64) begin : g_bad_aw
         $error("address width exceeds entry width");
      end
      if (INVAL_BIT >= PAGE_SHIFT || TAG_LSB + 1 >= PAGE_SHIFT) begin : g_bad_flags
         $error("entry flag bits overlap the address field");
      end
   endgenerate

   logic [1:0] tag;
   assign tag        = entry[TAG_LSB +: 2];
   assign next_base  = entry[AW-1:0] & ~LOW_MASK;
   assign page_inval = entry[INVAL_BIT];

   always_comb begin
      case (level)
         LVL_REGION:  usable = (tag == TAG_REGION)  && (next_base != '0);
         LVL_SEGMENT: usable = (tag == TAG_SEGMENT) && (next_base != '0);
         default:     usable = (entry != 64'd0);
      endcase
   end
endmodule

// File: rtl/dma_xlat_walker.sv
module dma_xlat_walker
   import dma_xlat_pkg::*;
#(
   parameter int            AW         = 64,
   parameter int            PAGE_SHIFT = 12,
   parameter int            PX_W       = 8,
   parameter int            SX_W       = 11,
   parameter int            RX_W       = 11,
   parameter bit            MSI_EN     = 1'b1,
   parameter logic [AW-1:0] MSI_ADDR   = AW'(64'h0000_00FE_E000_0000)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_addr,
   input  logic [AW-1:0] cfg_origin,
   input  logic [AW-1:0] cfg_base,
   input  logic [AW-1:0] cfg_limit,
   output logic          resp_valid,
   output logic [AW-1:0] resp_addr,
   output logic [1:0]    resp_perm,
   output logic          err_valid,
   output logic [1:0]    err_cause,
   output logic          err_qual,
   output logic [AW-1:0] err_addr,
   output logic          fn_error,
   output logic          fn_blocked,
   output logic          mem_req_valid,
   input  logic          mem_req_ready,
   output logic [AW-1:0] mem_req_addr,
   input  logic          mem_rsp_valid,
   input  logic [63:0]   mem_rsp_data
);
   localparam logic [AW-1:0] LOW_MASK = (AW'(1) << PAGE_SHIFT) - AW'(1);

   generate
      if (PAGE_SHIFT < 4 || PAGE_SHIFT >= AW) begin : g_bad_page
         $error("page shift out of range");
      end
   endgenerate

   walk_st_e      st;
   level_e        lvl;
   logic [AW-1:0] addr_q;
   logic [AW-1:0] base_q;

   logic          is_msi, pre_fail, accept;
   logic [1:0]    pre_cause;
   logic [AW-1:0] next_base;
   logic          ent_ok, ent_inval;

   assign req_ready     = (st == ST_IDLE);
   assign accept        = req_valid && req_ready;
   assign mem_req_valid = (st == ST_ISSUE);

   dma_xlat_precheck #(.AW(AW), .MSI_ADDR(MSI_ADDR), .MSI_EN(MSI_EN)) u_pre (
      .addr(req_addr), .origin(cfg_origin), .base(cfg_base), .limit(cfg_limit),
      .is_msi(is_msi), .fail(pre_fail), .cause(pre_cause)
   );

   dma_xlat_index #(.AW(AW), .PAGE_SHIFT(PAGE_SHIFT), .PX_W(PX_W), .SX_W(SX_W), .RX_W(RX_W)) u_idx (
      .addr(addr_q), .table_base(base_q), .level(lvl), .entry_addr(mem_req_addr)
   );

   dma_xlat_entry_dec #(.AW(AW), .PAGE_SHIFT(PAGE_SHIFT)) u_dec (
      .entry(mem_rsp_data), .level(lvl), .next_base(next_base),
      .usable(ent_ok), .page_inval(ent_inval)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         lvl        <= LVL_REGION;
         addr_q     <= '0;
         base_q     <= '0;
         resp_valid <= 1'b0;
         resp_addr  <= '0;
         resp_perm  <= PERM_NONE;
         err_valid  <= 1'b0;
         err_cause  <= CAUSE_NONE;
         err_qual   <= 1'b0;
         err_addr   <= '0;
         fn_error   <= 1'b0;
         fn_blocked <= 1'b0;
      end else begin
         resp_valid <= 1'b0;
         err_valid  <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (accept) begin
                  addr_q <= req_addr;
                  base_q <= cfg_origin & ~LOW_MASK;
                  lvl    <= LVL_REGION;
                  if (is_msi) begin
                     resp_valid <= 1'b1;
                     resp_addr  <= req_addr;
                     resp_perm  <= PERM_RW;
                  end else if (pre_fail) begin
                     resp_valid <= 1'b1;
                     resp_addr  <= '0;
                     resp_perm  <= PERM_NONE;
                     err_valid  <= 1'b1;
                     err_cause  <= pre_cause;
                     err_qual   <= 1'b0;
                     err_addr   <= req_addr;
                     fn_error   <= 1'b1;
                     fn_blocked <= 1'b1;
                  end else begin
                     st <= ST_ISSUE;
                  end
               end
            end
            ST_ISSUE: begin
               if (mem_req_ready) st <= ST_WAIT;
            end
            ST_WAIT: begin
               if (mem_rsp_valid) begin
                  if (!ent_ok) begin
                     st         <= ST_IDLE;
                     resp_valid <= 1'b1;
                     resp_addr  <= '0;
                     resp_perm  <= PERM_NONE;
                     err_valid  <= 1'b1;
                     err_cause  <= CAUSE_WALK;
                     err_qual   <= 1'b1;
                     err_addr   <= addr_q;
                     fn_error   <= 1'b1;
                     fn_blocked <= 1'b1;
                  end else if (lvl == LVL_PAGE) begin
                     st         <= ST_IDLE;
                     resp_valid <= 1'b1;
                     resp_addr  <= {next_base[AW-1:PAGE_SHIFT], addr_q[PAGE_SHIFT-1:0]};
                     resp_perm  <= ent_inval ? PERM_NONE : PERM_RW;
                  end else begin
                     base_q <= next_base;
                     lvl    <= (lvl == LVL_REGION) ? LVL_SEGMENT : LVL_PAGE;
                     st     <= ST_ISSUE;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dma_xlat_checker.sv
module dma_xlat_checker #(
   parameter int AW = 64
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic          resp_valid,
   input logic [1:0]    resp_perm,
   input logic          err_valid,
   input logic [1:0]    err_cause,
   input logic          err_qual,
   input logic          fn_error,
   input logic          fn_blocked,
   input logic          mem_req_valid,
   input logic          mem_req_ready,
   input logic [AW-1:0] mem_req_addr,
   input logic          mem_rsp_valid
);
   logic outst, busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         outst <= 1'b0;
         busy  <= 1'b0;
      end else begin
         if (mem_req_valid && mem_req_ready) outst <= 1'b1;
         else if (mem_rsp_valid)             outst <= 1'b0;
         if (req_valid && req_ready) busy <= 1'b1;
         else if (resp_valid)        busy <= 1'b0;
      end
   end

   assert_one_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      outst |-> !mem_req_valid);

   assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !resp_valid) |-> !req_ready);

   assert_err_sets_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid |=> (fn_error && fn_blocked));

   assert_flags_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_error && fn_blocked) |=> (fn_error && fn_blocked));

   assert_err_no_perm_R2: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid |-> (resp_valid && resp_perm == 2'b00 && err_cause != 2'd0));

   assert_qual_walk_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (err_valid && err_qual) |-> (err_cause == 2'd3));
endmodule

bind dma_xlat_walker dma_xlat_checker #(.AW(AW)) u_chk (.*);

// File: tb/tb_dma_xlat_walker.sv
module tb_dma_xlat_walker;
   localparam int AW = 64;
   localparam logic [63:0] MSI = 64'h0000_00FE_E000_0000;
   localparam logic [63:0] RT = 64'h1_0000, ST = 64'h2_0000, PT = 64'h3_0000;

   logic clk = 0, rst_n = 0;
   always #2.5 clk = ~clk;

   logic          req_valid = 0, req_ready;
   logic [63:0]   req_addr = 0, cfg_origin = 0, cfg_base = 0, cfg_limit = 0;
   logic          resp_valid, err_valid, err_qual, fn_error, fn_blocked;
   logic [63:0]   resp_addr, err_addr, mem_req_addr, mem_rsp_data;
   logic [1:0]    resp_perm, err_cause;
   logic          mem_req_valid, mem_req_ready, mem_rsp_valid;

   dma_xlat_walker #(.MSI_ADDR(MSI)) dut (.*);

   typedef struct {
      logic [63:0] addr; logic [1:0] perm; logic err; logic [1:0] cause;
      logic qual; logic [63:0] req; int reads; string tag;
   } exp_t;

   exp_t q[$];
   logic [63:0] mem [logic [63:0]];
   int n_chk = 0, n_fail = 0, rd_cnt = 0, rdy_dly = 0, rsp_dly = 0;
   bit exp_sticky = 0;

   function automatic logic [63:0] rdm(logic [63:0] a);
      return mem.exists(a) ? mem[a] : 64'd0;
   endfunction

   task automatic chk(bit ok, string r, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", r, act, exp);
      end
   endtask

   function automatic exp_t model(logic [63:0] a, string tag);
      exp_t e;
      logic [63:0] re, se, pe;
      e.addr = 0; e.perm = 2'b00; e.err = 1; e.cause = 3; e.qual = 1;
      e.req = a; e.reads = 0; e.tag = tag;
      if (a == MSI) begin
         e.addr = a; e.perm = 2'b11; e.err = 0; e.cause = 0; e.qual = 0; return e;
      end
      if (cfg_origin == 0) begin e.cause = 1; e.qual = 0; return e; end
      if (a < cfg_base || a > cfg_limit) begin e.cause = 2; e.qual = 0; return e; end
      re = rdm((cfg_origin & ~64'hFFF) + 64'(a[41:31]) * 8); e.reads = 1;
      if (re[3:2] != 2'b11 || (re & ~64'hFFF) == 0) return e;
      se = rdm((re & ~64'hFFF) + 64'(a[30:20]) * 8); e.reads = 2;
      if (se[3:2] != 2'b10 || (se & ~64'hFFF) == 0) return e;
      pe = rdm((se & ~64'hFFF) + 64'(a[19:12]) * 8); e.reads = 3;
      if (pe == 0) return e;
      e.addr = {pe[63:12], a[11:0]}; e.perm = pe[10] ? 2'b00 : 2'b11;
      e.err = 0; e.cause = 0; e.qual = 0;
      return e;
   endfunction

   // memory responder
   initial begin
      mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
      forever begin
         @(negedge clk);
         if (mem_req_valid) begin
            logic [63:0] a;
            repeat (rdy_dly) @(negedge clk);
            a = mem_req_addr;
            mem_req_ready = 1;
            @(negedge clk);
            mem_req_ready = 0;
            rd_cnt++;
            for (int i = 0; i < rsp_dly; i++) begin
               @(negedge clk);
               chk(!mem_req_valid, "R8 second read while outstanding", 64'(mem_req_valid), 0);
            end
            mem_rsp_valid = 1; mem_rsp_data = rdm(a);
            @(negedge clk);
            mem_rsp_valid = 0;
         end
      end
   end

   // monitor / scoreboard
   initial forever begin
      @(negedge clk);
      if (rst_n && resp_valid) begin
         if (q.size() == 0) chk(0, "R9 unexpected response", 1, 0);
         else begin
            exp_t e;
            e = q.pop_front();
            chk(resp_addr == e.addr, {e.tag, " addr"}, resp_addr, e.addr);
            chk(resp_perm == e.perm, {e.tag, " perm"}, 64'(resp_perm), 64'(e.perm));
            chk(err_valid == e.err, {e.tag, " err_valid"}, 64'(err_valid), 64'(e.err));
            if (e.err) begin
               chk(err_cause == e.cause, {e.tag, " cause"}, 64'(err_cause), 64'(e.cause));
               chk(err_qual == e.qual, {e.tag, " qual"}, 64'(err_qual), 64'(e.qual));
               chk(err_addr == e.req, {e.tag, " err_addr"}, err_addr, e.req);
            end
            chk(rd_cnt == e.reads, {e.tag, " R4 read count"}, 64'(rd_cnt), 64'(e.reads));
            if (e.err) exp_sticky = 1;
            @(negedge clk);
            chk(fn_error == exp_sticky && fn_blocked == exp_sticky, "R9 sticky flags",
                64'({fn_error, fn_blocked}), 64'({exp_sticky, exp_sticky}));
         end
      end
   end

   task automatic xlate(logic [63:0] a, string tag);
      q.push_back(model(a, tag));
      rd_cnt = 0;
      @(negedge clk);
      req_valid = 1; req_addr = a;
      @(negedge clk);
      req_valid = 0;
      chk(!req_ready || q.size() == 0, "R9 ready during walk", 64'(req_ready), 0);
      wait (q.size() == 0);
      repeat (3) @(negedge clk);
   endtask

   function automatic logic [63:0] mk(int rx, int sx, int px, int off);
      return (64'(rx) << 31) | (64'(sx) << 20) | (64'(px) << 12) | 64'(off);
   endfunction

   initial begin
      repeat (50000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      mem[RT + 5*8]  = ST | 64'hC;        // region entry, tag 11
      mem[RT + 6*8]  = ST | 64'h8;        // wrong tag for region
      mem[ST + 7*8]  = PT | 64'h8;        // segment entry, tag 10
      mem[ST + 8*8]  = PT | 64'hC;        // wrong tag for segment
      mem[PT + 9*8]  = 64'h0000_00AB_CDE0_0000;
      mem[PT + 10*8] = 64'h0000_0000_1234_5400; // invalid bit 10
      mem[PT + 12*8] = 64'h0000_0007_7777_7000;
      repeat (3) @(negedge clk);
      chk(req_ready && !resp_valid && !err_valid && !mem_req_valid && !fn_error && !fn_blocked,
          "R10 reset state", {58'd0, req_ready, resp_valid, err_valid, mem_req_valid, fn_error, fn_blocked}, 64'h20);
      rst_n = 1;
      @(negedge clk);
      chk(req_ready && !fn_error, "R10 after release", 64'(req_ready), 1);

      cfg_origin = RT | 64'h5; cfg_base = 64'h1000; cfg_limit = 64'h0000_7FFF_FFFF_FFFF;
      xlate(mk(5, 7, 9, 'h123), "R7 R4 valid page");
      rdy_dly = 2; rsp_dly = 3;
      xlate(mk(5, 7, 12, 'hFFF), "R7 R8 slow memory");
      rdy_dly = 1; rsp_dly = 0;
      xlate(mk(5, 7, 10, 'h040), "R7 invalid page");
      cfg_origin = 0;
      xlate(MSI, "R1 bypass without origin");
      xlate(mk(5, 7, 9, 0), "R2 no origin");
      cfg_origin = RT;
      xlate(mk(5, 7, 11, 'h8), "R6 zero page entry");
      xlate(mk(6, 7, 9, 0), "R5 bad region tag");
      xlate(mk(5, 8, 9, 0), "R5 bad segment tag");
      xlate(mk(4, 7, 9, 0), "R5 empty region entry");
      xlate(64'h800, "R3 below base");
      xlate(64'h0000_8000_0000_0000, "R3 above limit");
      cfg_base = 64'h0000_7F00_0000_0000;
      xlate(MSI, "R1 bypass outside window");
      cfg_base = 64'h1000;
      xlate(mk(5, 7, 9, 'h7), "R7 after errors");

      @(negedge clk); rst_n = 0;
      @(negedge clk); rst_n = 1; exp_sticky = 0;
      @(negedge clk);
      chk(!fn_error && !fn_blocked, "R9 reset clears flags", 64'({fn_error, fn_blocked}), 0);
      rdy_dly = 0; rsp_dly = 1;
      xlate(mk(5, 7, 12, 'h321), "R4 walk after reset");

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule